// File: doc/BRIEF.md
# Serial ROM Streamer with Warm-up Window

This block plays out the contents of a 128-byte array on a single open-drain data line, one bit for each rising edge of a separate, slow transmit clock. No master selects an address: after reset the block stays silent for a fixed number of transmit-clock edges, then repeats the whole array indefinitely. Each byte goes out most significant bit first and is followed by an empty framing slot in which the line is released. After the last byte the address counter wraps to zero and streaming carries on.

The transmit clock is asynchronous to the system clock. It passes through a flop synchroniser, and each rising edge it shows becomes a one-cycle pulse that advances the streamer by exactly one bit slot. An enable from the mode controller lets the stream run or stops it. While the enable is low, the line is released and the bit and byte position are frozen. The array is a register file that is filled through a valid/ready write port. Its ready output is low only while reset is applied and the cycle after, so no other back-pressure exists: a write is taken on each clock edge where both valid and ready are high. The byte that is due next is fetched into a holding register before its first bit is needed.

Top module: `vclk_rom_streamer`

## Requirements
- R1: During reset and right after it, `sda_oe` is 0. `wr_ready` is 1 from the second clock after reset is released.
- R2: For the first nine transmit-clock rising edges seen with `stream_en` high after reset, `sda_oe` stays 0.
- R3: On the tenth such edge, the block drives (`sda_oe`=1) bit 7 of the byte at address 0.
- R4: Each later enabled edge in a data slot drives the next bit of the current byte, bit 7 first and bit 0 last.
- R5: After bit 0 of a byte, the next enabled edge is a null slot: `sda_oe`=0 and `sda_out`=1. The edge after it starts the next byte.
- R6: Bytes go out in increasing address order. After address 127 the next byte comes from address 0.
- R7: While `stream_en` is 0, `sda_oe` is 0 from the next clock on. Edges in that time do not move the warm-up count, the bit position or the address.
- R8: One rising edge of `vclk_in` advances the stream by exactly one slot, however long the clock stays high. The outputs do not change while the transmit clock is steady.
- R9: A write with `wr_valid` and `wr_ready` both high stores `wr_data` at `wr_addr`. Later streaming of that address sends the stored byte.
- R10: A reset in the middle of the stream restarts the nine-edge warm-up and begins again at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vclk_in | input | 1 | Asynchronous transmit clock |
| stream_en | input | 1 | Lets the stream run when high |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write port can accept |
| wr_addr | input | 7 | Write byte address |
| wr_data | input | 8 | Write byte value |
| sda_oe | output | 1 | Drives the data line when high |
| sda_out | output | 1 | Data value when driven (1 when released) |

## Verification
The assertions assume that `vclk_in` stays at each level for at least three system clocks, so that the synchroniser sees every edge. They also assume that `stream_en` changes only while the transmit clock is steady, and that writes to the array happen outside active streaming. The stimulus holds `vclk_in` high and low for eight clocks each. It toggles the enable at random, and only with the transmit clock low and two clocks before the next edge. It fills the array while the enable is low, or before any edge. Random contents come from a fixed seed, and directed parts cover the warm-up limit, the wrap past address 127 and a reset in the middle of a byte.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  localparam int unsigned ROM_AW_DEF     = 7;
  localparam int unsigned ROM_DW_DEF     = 8;
  localparam int unsigned WARM_EDGES_DEF = 9;
  localparam int unsigned SYNC_DEF       = 2;

  typedef enum logic [0:0] {
    SEQ_WARMUP = 1'b0,
    SEQ_STREAM = 1'b1
  } seq_phase_e;
endpackage

// File: rtl/vrs_edge_sync.sv
module vrs_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  // One extra stage past the synchroniser holds the previous level.
  localparam int unsigned CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '1;
    end else begin
      chain_q <= {chain_q[CHAIN_W-2:0], async_in};
    end
  end

  assign rise_pulse = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/vrs_regfile.sv
module vrs_regfile #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/vrs_sequencer.sv
module vrs_sequencer
  import vrs_pkg::*;
#(
  parameter int unsigned AW         = 7,
  parameter int unsigned DW         = 8,
  parameter int unsigned WARM_EDGES = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          enable,
  input  logic [DW-1:0] fetch_data,
  output logic [AW-1:0] fetch_addr,
  output logic          line_oe,
  output logic          line_val,
  output logic          warm_done,
  output logic [$clog2(DW+1)-1:0] slot,
  output logic [AW-1:0] addr
);
  localparam int unsigned SLOT_W = $clog2(DW + 1);
  localparam int unsigned WARM_W = $clog2(WARM_EDGES + 1);
  localparam logic [SLOT_W-1:0] NULL_SLOT = SLOT_W'(DW);
  localparam logic [WARM_W-1:0] WARM_LAST = WARM_W'(WARM_EDGES - 1);

  seq_phase_e         phase_q;
  logic [WARM_W-1:0]  warm_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [AW-1:0]      addr_q;
  logic [DW-1:0]      byte_q;
  logic [DW-1:0]      shifted;
  logic               oe_q;
  logic               val_q;

  // Prefetch: during warm-up the first byte, while streaming the following one.
  assign fetch_addr = (phase_q == SEQ_STREAM) ? addr_q + AW'(1) : addr_q;

  always_comb begin
    shifted = byte_q << slot_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= SEQ_WARMUP;
      warm_q  <= '0;
      slot_q  <= '0;
      addr_q  <= '0;
      byte_q  <= '0;
      oe_q    <= 1'b0;
      val_q   <= 1'b1;
    end else if (!enable) begin
      oe_q  <= 1'b0;
      val_q <= 1'b1;
    end else if (step) begin
      case (phase_q)
        SEQ_WARMUP: begin
          oe_q   <= 1'b0;
          val_q  <= 1'b1;
          warm_q <= warm_q + WARM_W'(1);
          if (warm_q == WARM_LAST) begin
            phase_q <= SEQ_STREAM;
            byte_q  <= fetch_data;
          end
        end
        default: begin
          if (slot_q == NULL_SLOT) begin
            oe_q   <= 1'b0;
            val_q  <= 1'b1;
            slot_q <= '0;
            addr_q <= addr_q + AW'(1);
            byte_q <= fetch_data;
          end else begin
            oe_q   <= 1'b1;
            val_q  <= shifted[DW-1];
            slot_q <= slot_q + SLOT_W'(1);
          end
        end
      endcase
    end
  end

  assign line_oe   = oe_q;
  assign line_val  = val_q;
  assign warm_done = (phase_q == SEQ_STREAM);
  assign slot      = slot_q;
  assign addr      = addr_q;
endmodule

// File: rtl/vclk_rom_streamer.sv
module vclk_rom_streamer
  import vrs_pkg::*;
#(
  parameter int unsigned ROM_AW     = ROM_AW_DEF,
  parameter int unsigned ROM_DW     = ROM_DW_DEF,
  parameter int unsigned WARM_EDGES = WARM_EDGES_DEF,
  parameter int unsigned SYNC       = SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vclk_in,
  input  logic              stream_en,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ROM_AW-1:0] wr_addr,
  input  logic [ROM_DW-1:0] wr_data,
  output logic              sda_oe,
  output logic              sda_out
);
  localparam int unsigned SLOT_W = $clog2(ROM_DW + 1);

  logic              vclk_rise;
  logic              rdy_q;
  logic [ROM_AW-1:0] fetch_addr;
  logic [ROM_DW-1:0] fetch_data;
  logic              warm_done;
  logic [SLOT_W-1:0] seq_slot;
  logic [ROM_AW-1:0] seq_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign wr_ready = rdy_q;

  vrs_edge_sync #(.STAGES(SYNC)) i_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_in   (vclk_in),
    .rise_pulse (vclk_rise)
  );

  vrs_regfile #(.AW(ROM_AW), .DW(ROM_DW)) i_rf (
    .clk   (clk),
    .we    (wr_valid & rdy_q),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (fetch_addr),
    .rdata (fetch_data)
  );

  vrs_sequencer #(.AW(ROM_AW), .DW(ROM_DW), .WARM_EDGES(WARM_EDGES)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (vclk_rise),
    .enable     (stream_en),
    .fetch_data (fetch_data),
    .fetch_addr (fetch_addr),
    .line_oe    (sda_oe),
    .line_val   (sda_out),
    .warm_done  (warm_done),
    .slot       (seq_slot),
    .addr       (seq_addr)
  );
endmodule

// File: rtl/vrs_checker.sv
module vrs_checker #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input logic clk,
  input logic rst_n,
  input logic stream_en,
  input logic step,
  input logic sda_oe,
  input logic sda_out,
  input logic warm_done,
  input logic [$clog2(DW+1)-1:0] slot,
  input logic [AW-1:0] addr
);
  localparam logic [$clog2(DW+1)-1:0] NULL_SLOT = ($clog2(DW+1))'(DW);

  // R2: silent until the warm-up edges are done
  a_r2_quiet_warmup: assert property (@(posedge clk) disable iff (!rst_n)
    !warm_done |-> !sda_oe);

  // R5: the slot after bit 0 releases the line
  a_r5_null_release: assert property (@(posedge clk) disable iff (!rst_n)
    (step && stream_en && warm_done && slot == NULL_SLOT) |=> (!sda_oe && sda_out));

  // R6: address wraps to zero after the top entry
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && stream_en && slot == NULL_SLOT && addr == '1) |=> (addr == '0));

  // R7: disabled means released and frozen
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    !stream_en |=> !sda_oe);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stream_en |=> ($stable(slot) && $stable(addr)));

  // R8: nothing moves without an edge
  a_r8_no_step_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && stream_en) |=> ($stable(slot) && $stable(addr) && $stable(sda_oe) && $stable(sda_out)));

  // R4: slot never exceeds the null position
  a_r4_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= NULL_SLOT);
endmodule

bind vclk_rom_streamer vrs_checker #(.AW(ROM_AW), .DW(ROM_DW)) i_vrs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .stream_en (stream_en),
  .step      (vclk_rise),
  .sda_oe    (sda_oe),
  .sda_out   (sda_out),
  .warm_done (warm_done),
  .slot      (seq_slot),
  .addr      (seq_addr)
);

// File: tb/test_vclk_rom_streamer.sv
module test_vclk_rom_streamer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vclk_in = 1'b0;
  logic       stream_en = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [6:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sda_oe;
  logic       sda_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  logic [7:0] mem_m [DEPTH];
  int  m_warm, m_slot, m_addr;
  bit  m_oe, m_out;
  bit  m_wrapped;
  string m_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  vclk_rom_streamer i_vclk_rom_streamer (
    .clk(clk), .rst_n(rst_n), .vclk_in(vclk_in), .stream_en(stream_en),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .sda_oe(sda_oe), .sda_out(sda_out)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    m_warm = 0; m_slot = 0; m_addr = 0; m_oe = 0; m_out = 1;
  endfunction

  function automatic void model_step(input bit en);
    if (!en) begin
      m_oe = 0; m_out = 1; m_tag = "R7 disabled edge";
    end else if (m_warm < 9) begin
      m_warm++; m_oe = 0; m_out = 1; m_tag = "R2 warm-up";
    end else if (m_slot < 8) begin
      m_oe = 1;
      m_out = mem_m[m_addr][7 - m_slot];
      if (m_warm == 9 && m_addr == 0 && m_slot == 0 && !m_wrapped) m_tag = "R3 first bit";
      else if (m_wrapped && m_addr == 0) m_tag = "R6 wrapped byte";
      else m_tag = "R4 data bit";
      m_slot++;
    end else begin
      m_oe = 0; m_out = 1; m_slot = 0;
      m_addr = (m_addr + 1) % DEPTH;
      if (m_addr == 0) m_wrapped = 1;
      m_tag = "R5 null slot";
    end
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; vclk_in = 0; stream_en = 0; wr_valid = 0;
    repeat (3) @(negedge clk);
    check("R1 oe in reset", {7'd0, sda_oe}, 8'd0);
    rst_n = 1;
    model_reset();
    repeat (2) @(negedge clk);
    check("R1 oe after reset", {7'd0, sda_oe}, 8'd0);
    check("R1 wr_ready", {7'd0, wr_ready}, 8'd1);
  endtask

  task automatic write_byte(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    check("R9 ready before write", {7'd0, wr_ready}, 8'd1);
    wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
    mem_m[a] = d;
  endtask

  task automatic vpulse(input bit en);
    @(negedge clk);
    stream_en = en;
    repeat (2) @(negedge clk);
    vclk_in = 1;
    model_step(en);
    repeat (8) @(negedge clk);
    check({m_tag, " oe"}, {7'd0, sda_oe}, {7'd0, m_oe});
    check({m_tag, " out"}, {7'd0, sda_out}, {7'd0, m_out});
    vclk_in = 0;
    repeat (8) @(negedge clk);
    check("R8 stable oe", {7'd0, sda_oe}, {7'd0, m_oe});
    check("R8 stable out", {7'd0, sda_out}, {7'd0, m_out});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000 && !finished) begin
        finished = 1;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_wrapped = 0;
    m_tag = "";
    do_reset();
    // R9: fill the array through the write port
    for (int i = 0; i < DEPTH; i++) write_byte(7'(i), 8'($urandom));
    // directed corner bytes
    write_byte(7'd0, 8'hA5);
    write_byte(7'd127, 8'h3C);
    write_byte(7'd1, 8'h00);
    write_byte(7'd2, 8'hFF);

    // R2/R7: a disabled edge during warm-up does not count
    vpulse(1'b0);
    for (int i = 0; i < 9; i++) vpulse(1'b1);
    vpulse(1'b0);
    // R3: tenth enabled edge gives bit 7 of address 0
    vpulse(1'b1);

    // R4/R5/R6/R7: random enable across a full wrap
    while (!(m_wrapped && m_addr == 1)) begin
      vpulse(($urandom % 5) != 0);
    end

    // R10: reset mid-byte restarts warm-up at address 0
    vpulse(1'b1); vpulse(1'b1);
    do_reset();
    m_wrapped = 0;
    for (int i = 0; i < 9; i++) vpulse(1'b1);
    vpulse(1'b1);
    check("R10 restart at addr 0 msb", {7'd0, sda_out}, {7'd0, mem_m[0][7]});
    for (int i = 0; i < 12; i++) vpulse(1'b1);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule